// File: doc/BRIEF.md
# Cartridge Bus Target with Battery-Backed Save RAM

This block sits at the cartridge end of a byte-wide system bus. It answers two kinds of access. Reads in the program windows (address pages 0x08 through 0x0D) return bytes from a read-only program image. Accesses in the two top pages (0x0E and 0x0F) reach a battery-backed save RAM. The save RAM is live only when a static save-kind input selects the SRAM kind. The host drives a 32-bit address, a request strobe, a write enable and a write byte. A registered read byte comes back one clock later.

The save RAM comes up erased, with every byte 0xFF. A small state machine can return it to that state. It has two states. SR_READY is the normal serving state. SR_WIPE is an erase sweep that writes 0xFF to one location per clock. There are three transitions:
- A synchronous reset taken while the erase input is high enters SR_WIPE with the sweep pointer at zero.
- The last pointer value returns the machine to SR_READY.
- A reset taken without erase goes to SR_READY and leaves the stored bytes as they are.

While SR_WIPE is active, bus writes to the save window are dropped and reads return 0x00. The program image is generated by a fixed byte function of the offset. Its length is a parameter. Reads past its end return a filler byte.

Top module: `cart_bus_target`

## Requirements
- R1: While reset is high, and after it, `rdata` is 0x00 until the first read. A reset with `erase_req` low leaves the save RAM contents unchanged.
- R2: A read is `req`=1 with `we`=0, sampled at a rising edge. Its byte appears on `rdata` after that edge. In any cycle without a read, `rdata` holds its value.
- R3: Save-kind codes are 0 EEPROM, 1 SRAM, 2 FLASH, 3 FLASH512 and 4 FLASH1M. With code 1, a byte written to the save window reads back unchanged.
- R4: The save window is address[31:24] equal to 0x0E or 0x0F. Both pages use offset address[SAVE_AW-1:0], so the two pages alias. Higher offset bits are ignored, so the space repeats through each page. SAVE_AW is 15 for the full 32 KiB.
- R5: Before any write, every save location reads 0xFF.
- R6: The program windows are pages 0x08 to 0x0D, with offset address[24:0]. For an offset below ROM_BYTES, a read returns ((off[7:0] ^ {off[11:8], off[15:12]}) + 0x3C) mod 256.
- R7: A program-window read whose offset is at or above ROM_BYTES returns 0xDD.
- R8: With any save-kind code other than 1, save-window reads return 0x00 and save-window writes leave the stored bytes unchanged.
- R9: Writes to the program windows change neither the program bytes nor the save RAM.
- R10: A reset with `erase_req` high starts a sweep of 2^SAVE_AW clocks after reset is released. During the sweep, save-window reads return 0x00 and save-window writes are dropped. Afterwards every save location reads 0xFF.
- R11: Pages outside 0x08 to 0x0F read 0x00. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| erase_req | input | 1 | When high during reset, starts the erase sweep |
| save_kind | input | 3 | Static save-type code (1 enables the save RAM) |
| req | input | 1 | Access strobe |
| we | input | 1 | 1 = write, 0 = read, qualified by `req` |
| addr | input | 32 | Byte address; bits [31:24] select the page |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |

## Verification
The bench targets these corner cases:
- Address 0x0900_0010 sits in a program page but has offset bit 24 set. A decoder that masked the offset to 24 bits would return image data there instead of 0xDD.
- Page 0x1E shares its low nibble with the save page. A decoder looking at too few address bits would alias it into the save RAM.
- Save writes land at offsets beyond 2^SAVE_AW and in page 0x0F, then are read back through page 0x0E. A design that did not mirror correctly would return 0xFF or stale data.
- A write to an already-swept offset is issued while the erase sweep is running. A design that did not block such writes would read 0x55 back after the sweep.
- Writes are made under non-SRAM save kinds and are followed by a read once SRAM is selected again. A block that leaked those writes would show the new byte.

// File: rtl/cart_pkg.sv
package cart_pkg;

    typedef enum logic [2:0] {
        SK_EEPROM   = 3'd0,
        SK_SRAM     = 3'd1,
        SK_FLASH    = 3'd2,
        SK_FLASH512 = 3'd3,
        SK_FLASH1M  = 3'd4
    } save_kind_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_ROM,
        RG_SAVE
    } region_e;

    typedef enum logic {
        SR_READY,
        SR_WIPE
    } sweep_state_e;

    localparam int          ADDR_W      = 32;
    localparam int          DATA_W      = 8;
    localparam int          ROM_OFS_W   = 25;
    localparam logic [7:0]  PAGE_ROM_LO = 8'h08;
    localparam logic [7:0]  PAGE_ROM_HI = 8'h0D;
    localparam logic [7:0]  PAGE_SAVE_A = 8'h0E;
    localparam logic [7:0]  PAGE_SAVE_B = 8'h0F;
    localparam logic [7:0]  ROM_FILLER  = 8'hDD;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_pkg::*;
#(
    parameter int SAVE_AW = 10
) (
    input  logic [ADDR_W-1:0]    addr,
    output region_e              region,
    output logic [ROM_OFS_W-1:0] rom_ofs,
    output logic [SAVE_AW-1:0]   save_ofs
);

    logic [7:0] page;

    assign page     = addr[ADDR_W-1:ADDR_W-8];
    assign rom_ofs  = addr[ROM_OFS_W-1:0];
    assign save_ofs = addr[SAVE_AW-1:0];

    always_comb begin
        if (page >= PAGE_ROM_LO && page <= PAGE_ROM_HI) begin
            region = RG_ROM;
        end else if (page == PAGE_SAVE_A || page == PAGE_SAVE_B) begin
            region = RG_SAVE;
        end else begin
            region = RG_NONE;
        end
    end

endmodule

// File: rtl/cart_rom_image.sv
module cart_rom_image
    import cart_pkg::*;
#(
    parameter int ROM_BYTES = 4096
) (
    input  logic [ROM_OFS_W-1:0] ofs,
    output logic [DATA_W-1:0]    rom_q
);

    localparam logic [ROM_OFS_W:0] LIMIT = (ROM_OFS_W+1)'(ROM_BYTES);

    logic [7:0] pattern;

    assign pattern = (ofs[7:0] ^ {ofs[11:8], ofs[15:12]}) + 8'h3C;

    always_comb begin
        if ({1'b0, ofs} >= LIMIT) begin
            rom_q = ROM_FILLER;
        end else begin
            rom_q = pattern;
        end
    end

endmodule

// File: rtl/cart_save_ram.sv
module cart_save_ram
    import cart_pkg::*;
#(
    parameter int SAVE_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               erase_req,
    input  logic               wr_en,
    input  logic [SAVE_AW-1:0] ofs,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_byte,
    output logic               busy
);

    localparam int DEPTH = 1 << SAVE_AW;

    sweep_state_e       st;
    sweep_state_e       st_nxt;
    logic [SAVE_AW-1:0] ptr;
    logic [SAVE_AW-1:0] ptr_nxt;
    logic [DATA_W-1:0]  mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = ERASED_BYTE;
        end
    end

    always_comb begin
        st_nxt  = st;
        ptr_nxt = ptr;
        unique case (st)
            SR_READY: begin
                st_nxt = SR_READY;
            end
            SR_WIPE: begin
                ptr_nxt = ptr + 1'b1;
                if (ptr == {SAVE_AW{1'b1}}) begin
                    st_nxt = SR_READY;
                end
            end
            default: begin
                st_nxt = SR_READY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= erase_req ? SR_WIPE : SR_READY;
            ptr <= '0;
        end else begin
            st  <= st_nxt;
            ptr <= ptr_nxt;
        end
    end

    always @(posedge clk) begin
        if (st == SR_WIPE) begin
            mem[ptr] <= ERASED_BYTE;
        end else if (wr_en && !rst) begin
            mem[ofs] <= wdata;
        end
    end

    assign rd_byte = mem[ofs];
    assign busy    = (st == SR_WIPE);

    // R10: the sweep pointer advances one location per clock until the last
    p_wipe_step_r10: assert property (@(posedge clk) disable iff (rst)
        (st == SR_WIPE && ptr != {SAVE_AW{1'b1}}) |=>
        (st == SR_WIPE && ptr == $past(ptr) + 1'b1));

    // R10: the sweep leaves through the last location only
    p_wipe_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (st == SR_WIPE && ptr == {SAVE_AW{1'b1}}) |=> st == SR_READY);

endmodule

// File: rtl/cart_bus_target.sv
module cart_bus_target
    import cart_pkg::*;
#(
    parameter int ROM_BYTES = 4096,
    parameter int SAVE_AW   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        erase_req,
    input  logic [2:0]  save_kind,
    input  logic        req,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);

    region_e              region;
    logic [ROM_OFS_W-1:0] rom_ofs;
    logic [SAVE_AW-1:0]   save_ofs;
    logic [DATA_W-1:0]    rom_q;
    logic [DATA_W-1:0]    save_q;
    logic                 save_busy;
    logic                 save_on;
    logic                 save_wr;
    logic                 rd_strobe;

    cart_addr_decode #(.SAVE_AW(SAVE_AW)) u_decode (
        .addr     (addr),
        .region   (region),
        .rom_ofs  (rom_ofs),
        .save_ofs (save_ofs)
    );

    cart_rom_image #(.ROM_BYTES(ROM_BYTES)) u_rom (
        .ofs   (rom_ofs),
        .rom_q (rom_q)
    );

    assign save_on   = (save_kind == SK_SRAM);
    assign save_wr   = req && we && (region == RG_SAVE) && save_on && !save_busy;
    assign rd_strobe = req && !we;

    cart_save_ram #(.SAVE_AW(SAVE_AW)) u_save (
        .clk       (clk),
        .rst       (rst),
        .erase_req (erase_req),
        .wr_en     (save_wr),
        .ofs       (save_ofs),
        .wdata     (wdata),
        .rd_byte   (save_q),
        .busy      (save_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_strobe) begin
            unique case (region)
                RG_ROM:  rdata <= rom_q;
                RG_SAVE: rdata <= (save_on && !save_busy) ? save_q : 8'h00;
                default: rdata <= 8'h00;
            endcase
        end
    end

    // R2: without a read strobe the returned byte is held
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rdata));

    // R7: program reads past the image end give the filler byte
    p_rom_tail_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && region == RG_ROM &&
         {1'b0, rom_ofs} >= (ROM_OFS_W+1)'(ROM_BYTES)) |=> rdata == ROM_FILLER);

    // R8: save-window reads under a non-SRAM kind give zero
    p_nosave_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && region == RG_SAVE && !save_on) |=> rdata == 8'h00);

    // R10: save-window reads during the sweep give zero
    p_busy_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && region == RG_SAVE && save_busy) |=> rdata == 8'h00);

    // R11: reads of unmapped pages give zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && region == RG_NONE) |=> rdata == 8'h00);

endmodule

// File: tb/cart_bus_target_tb.sv
module cart_bus_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROM_BYTES  = 4096;
    localparam int SAVE_AW    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        erase_req = 1'b0;
    logic [2:0]  save_kind = 3'd1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    logic  pend     = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    cart_bus_target #(.ROM_BYTES(ROM_BYTES), .SAVE_AW(SAVE_AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .erase_req (erase_req),
        .save_kind (save_kind),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_exp(input logic [31:0] a);
        logic [24:0] off;
        off = a[24:0];
        if (int'(off) >= ROM_BYTES) return 8'hDD;
        return (off[7:0] ^ {off[11:8], off[15:12]}) + 8'h3C;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk) pend <= req && !we && !rst;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R2: unexpected read result %02h", rdata);
            end else begin
                check(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [31:0] a, input logic [7:0] exp, input string tag);
        req = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset(input logic erase, input int cycles);
        rst = 1'b1; erase_req = erase;
        repeat (cycles) @(negedge clk);
        rst = 1'b0; erase_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0, 3);
        check(rdata, 8'h00, "R1 reset value");

        // R5 erased contents
        rd(32'h0E00_0005, 8'hFF, "R5 erased byte");
        rd(32'h0E00_03FF, 8'hFF, "R5 erased top byte");

        // R3 / R4 round trip and mirrors
        wr(32'h0E00_0010, 8'hA5);
        rd(32'h0E00_0010, 8'hA5, "R3 round trip");
        rd(32'h0F00_0010, 8'hA5, "R4 page alias");
        rd(32'h0E00_0410, 8'hA5, "R4 offset mirror");
        wr(32'h0F00_07FF, 8'h3C);
        rd(32'h0E00_03FF, 8'h3C, "R4 write via upper page");

        // R6 / R7 program image, back to back
        rd(32'h0800_0000, rom_exp(32'h0800_0000), "R6 image start");
        rd(32'h0800_0123, rom_exp(32'h0800_0123), "R6 image mid");
        rd(32'h0A00_0FFF, rom_exp(32'h0A00_0FFF), "R6 last byte");
        rd(32'h0D00_0800, rom_exp(32'h0D00_0800), "R6 top page");
        rd(32'h0800_1000, 8'hDD, "R7 first past end");
        rd(32'h0900_0010, 8'hDD, "R7 offset bit 24");
        rd(32'h0C1F_FFFF, 8'hDD, "R7 far offset");

        // R2 hold across idle and write cycles
        drain();
        repeat (2) @(negedge clk);
        check(rdata, 8'hDD, "R2 hold idle");
        wr(32'h0E00_0200, 8'h42);
        @(negedge clk);
        check(rdata, 8'hDD, "R2 hold over write");

        // R9 writes to program windows
        wr(32'h0800_0123, 8'h00);
        rd(32'h0800_0123, rom_exp(32'h0800_0123), "R9 image unchanged");
        rd(32'h0E00_0123, 8'hFF, "R9 save untouched");

        // R8 non-SRAM kinds
        drain();
        save_kind = 3'd2;
        rd(32'h0E00_0010, 8'h00, "R8 flash read zero");
        wr(32'h0E00_0010, 8'h11);
        save_kind = 3'd0;
        rd(32'h0E00_0010, 8'h00, "R8 eeprom read zero");
        wr(32'h0F00_0010, 8'h22);
        save_kind = 3'd4;
        wr(32'h0E00_0010, 8'h33);
        drain();
        save_kind = 3'd1;
        rd(32'h0E00_0010, 8'hA5, "R8 writes dropped");

        // R11 unmapped pages
        rd(32'h0300_0000, 8'h00, "R11 low page");
        rd(32'h1E00_0010, 8'h00, "R11 page 0x1E");
        wr(32'h0200_0010, 8'h77);
        wr(32'h1E00_0010, 8'h77);
        rd(32'h0E00_0010, 8'hA5, "R11 write no effect");

        // R1 plain reset keeps contents
        drain();
        do_reset(1'b0, 2);
        check(rdata, 8'h00, "R1 reset clears read byte");
        rd(32'h0E00_0010, 8'hA5, "R1 contents kept");
        rd(32'h0E00_0200, 8'h42, "R1 second byte kept");

        // R10 erase sweep
        drain();
        do_reset(1'b1, 2);
        repeat (4) @(negedge clk);
        rd(32'h0E00_0010, 8'h00, "R10 read during sweep");
        wr(32'h0E00_0001, 8'h55);
        repeat ((1 << SAVE_AW) + 8) @(negedge clk);
        rd(32'h0E00_0001, 8'hFF, "R10 write during sweep dropped");
        rd(32'h0E00_0010, 8'hFF, "R10 erased");
        rd(32'h0F00_03FF, 8'hFF, "R10 erased top");
        rd(32'h0E00_0200, 8'hFF, "R10 erased mid");
        wr(32'h0E00_0020, 8'h5A);
        rd(32'h0E00_0020, 8'h5A, "R10 writable after sweep");
        drain();
        finish_run();
    end

endmodule